// File: doc/BRIEF.md
# ARINC 429 Receive Bit Validator

This block sits behind a comparator front end on an ARINC 429 receive line. The front end provides two synchronized level flags, one for a positive differential level and one for a negative one. When both flags are low, the line is at NULL. The block samples these flags on a sample tick. In high-speed mode the tick fires on every reference clock. In low-speed mode it fires on every eighth reference clock. Each line state has its own 10-stage history register.

A data bit is accepted when a confirmed run of ONE or ZERO, at least three samples long, sits in the three oldest stages. The three newest stages must at the same time hold a confirmed NULL run. When a bit is accepted, the block emits a one-clock strobe carrying the bit value and then clears its history.

With frequency discrimination enabled, the block checks the interval between an accepted bit and the previous one, counted in sample ticks. A bit that is too late is rejected and raises a one-clock error pulse. After a long idle stretch, the next bit starts a fresh timing reference. A sample with both level flags set is illegal and also raises the error pulse. Word assembly and the host side are left to later stages.

Top module: `a429_bit_validator`

## Requirements
- R1: After reset, bit_valid_o, bit_value_o and err_o are all 0.
- R2: With low_speed_i=0, the inputs are sampled on every clock. With low_speed_i=1, they are sampled once every 8 clocks, so a level held for 8 clocks counts as exactly one sample.
- R3: A bit is accepted only when ONE (one_i=1, zero_i=0) or ZERO (zero_i=1, one_i=0) fills history stages 9..7 and NULL (both 0) fills stages 2..0. Stage 0 holds the newest sample. A pulse of only 2 samples is never accepted.
- R4: An accepted bit gives a bit_valid_o pulse one clock wide, in the cycle after the clock edge that sampled the final NULL. bit_value_o is 1 for ONE and 0 for ZERO. For a bit of h ONE/ZERO samples (3..7) followed by NULL samples, that final NULL is the bit's 10th sample.
- R5: Every history register is cleared on acceptance, so one pulse produces exactly one strobe, whatever its length.
- R6: With freq_chk_en_i=1, an accepted bit must follow the previous accepted bit by 8 to 12 sample ticks. A bit arriving 13 to 29 ticks after the previous one gets no strobe. Instead it produces a one-clock err_o pulse, and the bit that follows it is timed as a first bit.
- R7: A bit arriving 30 or more ticks after the previous accepted bit, or the first bit after reset, is treated as the start of a word and is not spacing-checked.
- R8: With freq_chk_en_i=0, the spacing check is skipped and no spacing error is raised for any interval.
- R9: A sample with one_i and zero_i both 1 gives a one-clock err_o pulse in the next cycle. In the history registers it counts as neither ONE, ZERO nor NULL.
- R10: In low-speed mode, the spacing window is counted in samples, so a 14-sample interval raises err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| one_i | input | 1 | Line at positive level (synchronized) |
| zero_i | input | 1 | Line at negative level (synchronized) |
| low_speed_i | input | 1 | 1 selects one sample per 8 clocks |
| freq_chk_en_i | input | 1 | 1 enables the bit spacing check |
| bit_valid_o | output | 1 | One-clock strobe for an accepted bit |
| bit_value_o | output | 1 | Value of the accepted bit |
| err_o | output | 1 | One-clock pulse on a spacing violation or an illegal sample |

## Verification
The hardest case to reach is the spacing window boundary. A late bit only shows up when a full, well-formed bit lands 13 to 29 ticks after an accepted bit. A bit 30 ticks after an accepted bit must pass. The stimulus sends a reference bit whose trailing NULL is stretched, sweeping the interval from 10 to 31 ticks, and then sends two normal bits. From the interval alone, the bench predicts the strobe count, the bit values and the error count. This also confirms that the bit after an error is timed as a first bit. The double-count hazard is covered by a single pulse with a long high phase followed by a long NULL phase. Illegal samples are placed inside a pulse to show that they break the run.

// File: rtl/a429_bv_pkg.sv
package a429_bv_pkg;
  typedef enum logic [1:0] {
    LVL_ONE  = 2'd0,
    LVL_ZERO = 2'd1,
    LVL_NULL = 2'd2
  } lvl_e;
  localparam int unsigned NUM_LVL = 3;
endpackage

// File: rtl/a429_bv_tick_gen.sv
module a429_bv_tick_gen #(
  parameter int unsigned LS_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_speed_i,
  output logic tick_o
);
  localparam int unsigned DW = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(LS_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + DW'(1);
  end

  assign tick_o = !low_speed_i || (div_q == DIV_LAST);
endmodule

// File: rtl/a429_bv_sampler.sv
module a429_bv_sampler
  import a429_bv_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned RUN   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic one_i,
  input  logic zero_i,
  output logic hit_o,
  output logic hit_val_o
);
  logic [NUM_LVL-1:0]            lvl_in;
  logic [NUM_LVL-1:0][DEPTH-1:0] hist_q, hist_nxt;
  logic [NUM_LVL-1:0]            run_old, run_new;

  // an illegal sample (both flags) shifts 0 into every register
  assign lvl_in[LVL_ONE]  = one_i & ~zero_i;
  assign lvl_in[LVL_ZERO] = zero_i & ~one_i;
  assign lvl_in[LVL_NULL] = ~one_i & ~zero_i;

  for (genvar s = 0; s < NUM_LVL; s++) begin : g_lvl
    assign hist_nxt[s] = {hist_q[s][DEPTH-2:0], lvl_in[s]};
    assign run_old[s]  = &hist_nxt[s][DEPTH-1 -: RUN];
    assign run_new[s]  = &hist_nxt[s][RUN-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[s] <= '0;
      else if (tick_i) hist_q[s] <= hit_o ? '0 : hist_nxt[s];
    end
  end

  logic hit_one, hit_zero;
  assign hit_one   = run_old[LVL_ONE]  & run_new[LVL_NULL];
  assign hit_zero  = run_old[LVL_ZERO] & run_new[LVL_NULL];
  assign hit_o     = tick_i & (hit_one | hit_zero);
  assign hit_val_o = hit_one;
endmodule

// File: rtl/a429_bv_spacing.sv
module a429_bv_spacing #(
  parameter int unsigned MIN_SP   = 8,
  parameter int unsigned MAX_SP   = 12,
  parameter int unsigned WORD_GAP = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic chk_en_i,
  output logic viol_o
);
  localparam int unsigned CW = $clog2(WORD_GAP + 1);
  localparam logic [CW-1:0] GAP_C = CW'(WORD_GAP);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_SP);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_SP);

  // saturated count means "no reference bit": first bit of a word
  logic [CW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = (cnt_q == GAP_C) ? GAP_C : cnt_q + CW'(1);
  assign viol_o  = hit_i && chk_en_i && (cnt_nxt < GAP_C) &&
                   ((cnt_nxt < MIN_C) || (cnt_nxt > MAX_C));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= GAP_C;
    else if (tick_i) begin
      if (hit_i) cnt_q <= viol_o ? GAP_C : '0;
      else       cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/a429_bit_validator.sv
module a429_bit_validator #(
  parameter int unsigned DEPTH    = 10,
  parameter int unsigned RUN      = 3,
  parameter int unsigned LS_DIV   = 8,
  parameter int unsigned MIN_SP   = 8,
  parameter int unsigned MAX_SP   = 12,
  parameter int unsigned WORD_GAP = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic one_i,
  input  logic zero_i,
  input  logic low_speed_i,
  input  logic freq_chk_en_i,
  output logic bit_valid_o,
  output logic bit_value_o,
  output logic err_o
);
  logic smp_tick, hit, hit_val, viol, illegal;

  a429_bv_tick_gen #(.LS_DIV(LS_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_speed_i(low_speed_i), .tick_o(smp_tick)
  );

  a429_bv_sampler #(.DEPTH(DEPTH), .RUN(RUN)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(smp_tick),
    .one_i(one_i), .zero_i(zero_i), .hit_o(hit), .hit_val_o(hit_val)
  );

  a429_bv_spacing #(.MIN_SP(MIN_SP), .MAX_SP(MAX_SP), .WORD_GAP(WORD_GAP)) u_sp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(smp_tick),
    .hit_i(hit), .chk_en_i(freq_chk_en_i), .viol_o(viol)
  );

  assign illegal = smp_tick & one_i & zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_valid_o <= 1'b0;
      bit_value_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      bit_valid_o <= hit & ~viol;
      err_o       <= illegal | (hit & viol);
      if (hit && !viol) bit_value_o <= hit_val;
    end
  end
endmodule

// File: rtl/a429_bv_chk.sv
module a429_bv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic one_i,
  input logic zero_i,
  input logic low_speed_i,
  input logic tick_i,
  input logic bit_valid_o,
  input logic err_o
);
  // R4: strobe is one clock wide
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  // R4: a strobe follows a tick that sampled NULL
  a_r4_after_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(tick_i && !one_i && !zero_i));

  // R6: a rejected bit never also strobes
  a_r6_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && err_o));

  // R9: illegal sample flagged next cycle
  a_r9_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && one_i && zero_i) |=> err_o);

  // R2: low-speed ticks are never back to back
  a_r2_low_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && low_speed_i) |=> (!tick_i || !low_speed_i));
endmodule

bind a429_bit_validator a429_bv_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .one_i(one_i), .zero_i(zero_i),
  .low_speed_i(low_speed_i), .tick_i(smp_tick),
  .bit_valid_o(bit_valid_o), .err_o(err_o)
);

// File: tb/a429_bit_validator_tb_top.sv
module a429_bit_validator_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic one_i = 1'b0, zero_i = 1'b0, low_speed = 1'b0, fchk = 1'b1;
  logic bit_valid, bit_value, err;

  always #2.5 clk = ~clk;

  a429_bit_validator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .one_i(one_i), .zero_i(zero_i),
    .low_speed_i(low_speed), .freq_chk_en_i(fchk),
    .bit_valid_o(bit_valid), .bit_value_o(bit_value), .err_o(err)
  );

  int checks = 0, errors = 0;
  int cyc = 0, spp = 1, exp_cyc = 0;
  int rx_cnt = 0, err_cnt = 0, last_rx_cyc = 0;
  logic [31:0] rx_bits = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        rx_cnt++;
        rx_bits = {rx_bits[30:0], bit_value};
        last_rx_cyc = cyc;
      end
      if (err) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input logic o, input logic z);
    for (int k = 0; k < spp; k++) begin
      @(negedge clk);
      one_i = o; zero_i = z;
    end
  endtask

  task automatic send_bit(input logic v, input int h, input int len);
    for (int i = 0; i < len; i++) begin
      if (i < h) sample(v, ~v);
      else       sample(1'b0, 1'b0);
      if (i == 9) exp_cyc = cyc + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sample(1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rx0, e0, nb;
    logic [3:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_valid == 0 && err == 0 && bit_value == 0, "R1 reset", int'({bit_valid, bit_value, err}), 0);

    // R3/R4 sweep: high phase 3..7 samples, bit length 10..12
    for (int h = 3; h <= 7; h++) begin
      for (int len = 10; len <= 12; len++) begin
        idle(35);
        rx0 = rx_cnt; e0 = err_cnt;
        pat = 4'(h * 5 + len);
        for (int b = 3; b >= 0; b--) send_bit(pat[b], h, len);
        idle(35);
        chk(rx_cnt - rx0 == 4, "R3 strobe count", rx_cnt - rx0, 4);
        chk(rx_bits[3:0] == pat, "R4 bit values", int'(rx_bits[3:0]), int'(pat));
        chk(err_cnt == e0, "R6 no error in window", err_cnt - e0, 0);
      end
    end

    // R4 latency
    idle(35);
    send_bit(1'b1, 5, 10);
    idle(12);
    chk(last_rx_cyc == exp_cyc, "R4 latency", last_rx_cyc, exp_cyc);

    // R3 two-sample pulses rejected
    rx0 = rx_cnt; e0 = err_cnt;
    send_bit(1'b1, 2, 10);
    send_bit(1'b0, 2, 10);
    idle(35);
    chk(rx_cnt == rx0, "R3 short pulse", rx_cnt - rx0, 0);

    // R5 long pulse counted once
    rx0 = rx_cnt;
    send_bit(1'b0, 7, 20);
    idle(35);
    chk(rx_cnt - rx0 == 1, "R5 single count", rx_cnt - rx0, 1);
    chk(rx_bits[0] == 1'b0, "R5 value", int'(rx_bits[0]), 0);

    // R9 illegal sample alone, then inside a pulse
    rx0 = rx_cnt; e0 = err_cnt;
    sample(1'b1, 1'b1);
    idle(5);
    chk(err_cnt - e0 == 1, "R9 illegal flagged", err_cnt - e0, 1);
    e0 = err_cnt;
    sample(1'b1, 1'b0); sample(1'b1, 1'b0); sample(1'b1, 1'b1);
    sample(1'b1, 1'b0); sample(1'b1, 1'b0);
    idle(35);
    chk(err_cnt - e0 == 1, "R9 illegal in pulse err", err_cnt - e0, 1);
    chk(rx_cnt == rx0, "R9 illegal breaks run", rx_cnt - rx0, 0);

    // R6/R7 spacing sweep 10..31
    for (int len = 10; len <= 31; len++) begin
      bit bad;
      bad = (len >= 13 && len <= 29);
      idle(35);
      rx0 = rx_cnt; e0 = err_cnt;
      send_bit(1'b1, 5, len);
      send_bit(1'b0, 5, 10);
      send_bit(1'b1, 5, 10);
      idle(35);
      nb = bad ? 2 : 3;
      chk(rx_cnt - rx0 == nb, bad ? "R6 late bit dropped" : "R7 spacing accepted", rx_cnt - rx0, nb);
      chk(err_cnt - e0 == int'(bad), "R6 spacing error", err_cnt - e0, int'(bad));
      if (bad) chk(rx_bits[1:0] == 2'b11, "R6 next bit first", int'(rx_bits[1:0]), 3);
      else     chk(rx_bits[2:0] == 3'b101, "R7 values", int'(rx_bits[2:0]), 5);
    end

    // R8 discrimination off
    fchk = 1'b0;
    for (int len = 13; len <= 20; len++) begin
      idle(35);
      rx0 = rx_cnt; e0 = err_cnt;
      send_bit(1'b1, 5, len);
      send_bit(1'b0, 5, 10);
      idle(35);
      chk(rx_cnt - rx0 == 2 && err_cnt == e0, "R8 no spacing check", rx_cnt - rx0, 2);
    end
    fchk = 1'b1;

    // R2/R10 low speed
    low_speed = 1'b1; spp = 8;
    idle(40);
    rx0 = rx_cnt; e0 = err_cnt;
    send_bit(1'b1, 5, 10); send_bit(1'b0, 5, 10); send_bit(1'b1, 5, 10);
    idle(35);
    chk(rx_cnt - rx0 == 3, "R2 low speed count", rx_cnt - rx0, 3);
    chk(rx_bits[2:0] == 3'b101 && err_cnt == e0, "R2 low speed values", int'(rx_bits[2:0]), 5);
    rx0 = rx_cnt;
    send_bit(1'b1, 2, 10);
    idle(35);
    chk(rx_cnt == rx0, "R2 16-clock pulse is 2 samples", rx_cnt - rx0, 0);
    rx0 = rx_cnt; e0 = err_cnt;
    send_bit(1'b1, 5, 14);
    send_bit(1'b0, 5, 10);
    idle(35);
    chk(rx_cnt - rx0 == 1 && err_cnt - e0 == 1, "R10 low speed late bit", err_cnt - e0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule